// File: doc/BRIEF.md
# Multiply-Accumulate Execution Unit

This unit carries out the multiply and multiply-accumulate instructions of a small RISC core. It owns a 64-bit accumulator held as two 32-bit halves, a high word and a low word. The core hands it a 16-bit instruction word, the two register operands and, for the accumulating forms, the two values already read from memory at the addresses those registers hold. The unit decodes the word, forms a signed or unsigned product, writes it to the accumulator or adds it there, and returns the two address registers advanced by the operand size.

Every legal instruction is held for a fixed number of cycles set by its class. Long forms are the 32-bit multiplies and both accumulating forms. Short forms are the two 16-bit non-accumulating multiplies. While an instruction is in flight the unit reports busy and ignores new requests. The cycle in which the results appear is marked by a one-cycle done pulse. A word that names none of the seven forms changes nothing and raises a one-cycle illegal-operation flag. The core's condition flag is never touched, and every form may run in any privilege mode.

Top module: `mac_unit`

## Requirements
- R1: Only bits 15:12 and 3:0 of the word select the form. The upper/lower nibble pairs are 3/D (signed 32x32 to 64), 3/5 (unsigned 32x32 to 64), 0/7 (32x32 low word), 2/F (signed 16x16), 2/E (unsigned 16x16), 0/F (32-bit accumulate) and 4/F (16-bit accumulate). Bits 11:4 have no effect.
- R2: The signed 32x32 form writes the 64-bit two's-complement product of Rn and Rm: the upper 32 bits go to the high word and the lower 32 bits to the low word.
- R3: The unsigned 32x32 form writes the 64-bit unsigned product of Rn and Rm the same way.
- R4: The 32x32 low-word form writes bits 31:0 of Rn times Rm to the low word and leaves the high word unchanged.
- R5: The 16x16 forms multiply bits 15:0 of Rn and Rm, sign-extended for the signed form and zero-extended for the unsigned form. The 32-bit product goes to the low word and the high word is unchanged.
- R6: The 32-bit accumulate form adds the signed product of the two 32-bit memory values to the 64-bit accumulator, wrapping modulo 2^64. Each returned pointer is the corresponding register plus 4.
- R7: The 16-bit accumulate form adds the signed product of bits 15:0 of the two memory values to the 64-bit accumulator, wrapping modulo 2^64. Each returned pointer is the register plus 2. All non-accumulating forms return the pointers unchanged.
- R8: If an instruction is accepted at edge k, busy is high for exactly L cycles, and the accumulator, the pointers and a one-cycle done pulse all appear after edge k+L. L is LONG_LAT for long forms and SHORT_LAT for short forms.
- R9: A request made while busy is high is dropped: it has no effect on the results and raises no flag.
- R10: A request whose word matches no form leaves every output except the flag unchanged. It keeps busy low and raises illegalOp for exactly one cycle, one edge after the request.
- R11: While reset is asserted, both accumulator words, both pointer outputs, busy, done and illegalOp are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| instrValid | input | 1 | Request strobe for instrWord |
| instrWord | input | 16 | Instruction word |
| rnVal | input | 32 | Value of register n |
| rmVal | input | 32 | Value of register m |
| memNVal | input | 32 | Memory value addressed by register n |
| memMVal | input | 32 | Memory value addressed by register m |
| busy | output | 1 | Instruction in flight |
| done | output | 1 | One-cycle pulse with new results |
| illegalOp | output | 1 | One-cycle flag for an unmatched word |
| machOut | output | 32 | Accumulator high word |
| maclOut | output | 32 | Accumulator low word |
| rnPtrOut | output | 32 | Returned value of register n |
| rmPtrOut | output | 32 | Returned value of register m |

## Verification
The assertions assume three things about the inputs: the latency parameters are at least one, the request and operand inputs carry known values on the edge where they are sampled, and the core drives inputs only between clock edges. The bench drives every input on the falling edge. It makes every operand known, including the memory values for forms that do not read them. It also issues requests while the unit is busy, which is legal at the interface, so that the drop rule is exercised without breaking any assumption.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_DMULS = 3'd1,
    OP_DMULU = 3'd2,
    OP_MULL  = 3'd3,
    OP_MULSW = 3'd4,
    OP_MULUW = 3'd5,
    OP_MACL  = 3'd6,
    OP_MACW  = 3'd7
  } macOp_e;

  typedef struct packed {
    logic   load;    // capture operands this edge
    logic   commit;  // write results this edge
    macOp_e op;      // decoded form, valid with load
  } macStrobe_t;

  function automatic macOp_e decodeOp(input logic [15:0] w);
    case ({w[15:12], w[3:0]})
      8'h3D:   decodeOp = OP_DMULS;
      8'h35:   decodeOp = OP_DMULU;
      8'h07:   decodeOp = OP_MULL;
      8'h2F:   decodeOp = OP_MULSW;
      8'h2E:   decodeOp = OP_MULUW;
      8'h0F:   decodeOp = OP_MACL;
      8'h4F:   decodeOp = OP_MACW;
      default: decodeOp = OP_NONE;
    endcase
  endfunction

  function automatic logic isShort(input macOp_e op);
    isShort = (op == OP_MULSW) || (op == OP_MULUW);
  endfunction

endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
#(
  parameter int LONG_LAT  = 3,
  parameter int SHORT_LAT = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       instrValid,
  input  logic [15:0] instrWord,
  output macStrobe_t stb,
  output logic       busy,
  output logic       done,
  output logic       illegalOp
);
  localparam int MAX_LAT = (LONG_LAT > SHORT_LAT) ? LONG_LAT : SHORT_LAT;
  localparam int CW      = $clog2(MAX_LAT + 1);

  logic [CW-1:0] cnt;
  macOp_e        decOp;
  logic          req;

  assign decOp = decodeOp(instrWord);
  assign req   = instrValid && !busy;

  always_comb begin
    stb.op     = decOp;
    stb.load   = req && (decOp != OP_NONE);
    stb.commit = busy && (cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      illegalOp <= 1'b0;
      cnt       <= '0;
    end else begin
      done      <= stb.commit;
      illegalOp <= req && (decOp == OP_NONE);
      if (stb.commit) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end else if (stb.load) begin
        busy <= 1'b1;
        cnt  <= isShort(decOp) ? CW'(SHORT_LAT - 1) : CW'(LONG_LAT - 1);
      end
    end
  end

  // R8: done lasts one cycle and marks the end of busy
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(busy) && !busy));
  // R10: the flag only follows an idle request and never starts work
  p_illegal_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |-> (!busy && !$past(busy)));
  // R9: no new load while an instruction is in flight
  p_no_load_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !stb.load);

endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  macStrobe_t    stb,
  input  logic [DW-1:0] rnVal,
  input  logic [DW-1:0] rmVal,
  input  logic [DW-1:0] memNVal,
  input  logic [DW-1:0] memMVal,
  output logic [DW-1:0] machOut,
  output logic [DW-1:0] maclOut,
  output logic [DW-1:0] rnPtrOut,
  output logic [DW-1:0] rmPtrOut
);
  localparam int AW = 2 * DW;
  localparam int HW = DW / 2;

  macOp_e        opQ;
  logic [DW-1:0] aQ, bQ, rnQ, rmQ;
  logic [AW-1:0] extA, extB, prod, accSum;
  logic [DW-1:0] ptrInc;
  logic          sgn, narrow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ <= OP_NONE;
      aQ  <= '0;
      bQ  <= '0;
      rnQ <= '0;
      rmQ <= '0;
    end else if (stb.load) begin
      opQ <= stb.op;
      rnQ <= rnVal;
      rmQ <= rmVal;
      if (stb.op == OP_MACL || stb.op == OP_MACW) begin
        aQ <= memNVal;
        bQ <= memMVal;
      end else begin
        aQ <= rnVal;
        bQ <= rmVal;
      end
    end
  end

  always_comb begin
    sgn    = (opQ != OP_DMULU) && (opQ != OP_MULUW);
    narrow = (opQ == OP_MULSW) || (opQ == OP_MULUW) || (opQ == OP_MACW);
    if (narrow) begin
      extA = {{(AW-HW){sgn & aQ[HW-1]}}, aQ[HW-1:0]};
      extB = {{(AW-HW){sgn & bQ[HW-1]}}, bQ[HW-1:0]};
    end else begin
      extA = {{(AW-DW){sgn & aQ[DW-1]}}, aQ};
      extB = {{(AW-DW){sgn & bQ[DW-1]}}, bQ};
    end
    prod   = extA * extB;
    accSum = {machOut, maclOut} + prod;
    case (opQ)
      OP_MACL: ptrInc = DW'(4);
      OP_MACW: ptrInc = DW'(2);
      default: ptrInc = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      machOut  <= '0;
      maclOut  <= '0;
      rnPtrOut <= '0;
      rmPtrOut <= '0;
    end else if (stb.commit) begin
      rnPtrOut <= rnQ + ptrInc;
      rmPtrOut <= rmQ + ptrInc;
      case (opQ)
        OP_DMULS, OP_DMULU: {machOut, maclOut} <= prod;
        OP_MACL, OP_MACW:   {machOut, maclOut} <= accSum;
        OP_MULL, OP_MULSW, OP_MULUW: maclOut <= prod[DW-1:0];
        default: ;
      endcase
    end
  end

  // R4, R5: low-word-only forms keep the high word
  p_mach_kept_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commit && (opQ == OP_MULL || opQ == OP_MULSW || opQ == OP_MULUW))
      |=> $stable(machOut));
  // R8: results move only on a commit
  p_hold_no_commit_r8: assert property (@(posedge clk) disable iff (!rstN)
    !stb.commit |=> ($stable(machOut) && $stable(maclOut) && $stable(rnPtrOut)));
  // R1: captured form is never the empty code after a load
  p_load_legal_r1: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> (opQ != OP_NONE));

endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int LONG_LAT  = 3,
  parameter int SHORT_LAT = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        instrValid,
  input  logic [15:0] instrWord,
  input  logic [31:0] rnVal,
  input  logic [31:0] rmVal,
  input  logic [31:0] memNVal,
  input  logic [31:0] memMVal,
  output logic        busy,
  output logic        done,
  output logic        illegalOp,
  output logic [31:0] machOut,
  output logic [31:0] maclOut,
  output logic [31:0] rnPtrOut,
  output logic [31:0] rmPtrOut
);
  macStrobe_t stb;

  mac_ctrl #(.LONG_LAT(LONG_LAT), .SHORT_LAT(SHORT_LAT)) u_ctrl (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .stb(stb), .busy(busy), .done(done), .illegalOp(illegalOp));

  mac_datapath #(.DW(32)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .rnVal(rnVal), .rmVal(rmVal), .memNVal(memNVal), .memMVal(memMVal),
    .machOut(machOut), .maclOut(maclOut), .rnPtrOut(rnPtrOut), .rmPtrOut(rmPtrOut));

endmodule

// File: tb/test_mac_unit.sv
module test_mac_unit;
  localparam int LONG  = 3;
  localparam int SHORT = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [15:0] instrWord = '0;
  logic [31:0] rnVal = '0, rmVal = '0, memNVal = '0, memMVal = '0;
  logic        busy, done, illegalOp;
  logic [31:0] machOut, maclOut, rnPtrOut, rmPtrOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string tag = "R11";

  mac_unit #(.LONG_LAT(LONG), .SHORT_LAT(SHORT)) i_mac_unit (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .rnVal(rnVal), .rmVal(rmVal), .memNVal(memNVal), .memMVal(memMVal),
    .busy(busy), .done(done), .illegalOp(illegalOp),
    .machOut(machOut), .maclOut(maclOut), .rnPtrOut(rnPtrOut), .rmPtrOut(rmPtrOut));

  always #4 clk = ~clk;   // 125 MHz

  // reference model state
  logic        mBusy, mDone, mIll;
  int          mLeft, mKind;
  logic [63:0] mAcc;
  logic [31:0] mRnPtr, mRmPtr, pA, pB, pRn, pRm;

  function automatic int kindOf(input logic [15:0] w);
    case ({w[15:12], w[3:0]})
      8'h3D: return 0;  8'h35: return 1;  8'h07: return 2;
      8'h2F: return 3;  8'h2E: return 4;  8'h0F: return 5;
      8'h4F: return 6;  default: return -1;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mDone = 0; mIll = 0; mLeft = 0; mKind = 0;
      mAcc = '0; mRnPtr = '0; mRmPtr = '0;
    end else begin
      mDone = 0; mIll = 0;
      if (mBusy) begin
        mLeft--;
        if (mLeft == 0) begin
          mBusy = 0; mDone = 1;
          mRnPtr = pRn; mRmPtr = pRm;
          case (mKind)
            0: mAcc = 64'(longint'($signed(pA)) * longint'($signed(pB)));
            1: mAcc = {32'h0, pA} * {32'h0, pB};
            2: mAcc[31:0] = pA * pB;
            3: mAcc[31:0] = 32'(int'($signed(pA[15:0])) * int'($signed(pB[15:0])));
            4: mAcc[31:0] = {16'h0, pA[15:0]} * {16'h0, pB[15:0]};
            5: begin
                 mAcc = mAcc + 64'(longint'($signed(pA)) * longint'($signed(pB)));
                 mRnPtr = pRn + 4; mRmPtr = pRm + 4;
               end
            default: begin
                 mAcc = mAcc + 64'(longint'($signed(pA[15:0])) * longint'($signed(pB[15:0])));
                 mRnPtr = pRn + 2; mRmPtr = pRm + 2;
               end
          endcase
        end
      end else if (instrValid) begin
        mKind = kindOf(instrWord);
        if (mKind < 0) mIll = 1;
        else begin
          mBusy = 1;
          mLeft = (mKind == 3 || mKind == 4) ? SHORT : LONG;
          pRn = rnVal; pRm = rmVal;
          pA = (mKind >= 5) ? memNVal : rnVal;
          pB = (mKind >= 5) ? memMVal : rmVal;
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    cycles++;
    chk(rstN ? "R8" : "R11", "busy", 32'(busy), 32'(mBusy));
    chk(rstN ? "R8" : "R11", "done", 32'(done), 32'(mDone));
    chk(rstN ? "R10" : "R11", "illegalOp", 32'(illegalOp), 32'(mIll));
    chk(tag, "mach", machOut, mAcc[63:32]);
    chk(tag, "macl", maclOut, mAcc[31:0]);
    chk(tag, "rnPtr", rnPtrOut, mRnPtr);
    chk(tag, "rmPtr", rmPtrOut, mRmPtr);
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic issue(input string t, input logic [15:0] w, input logic [31:0] rn, rm, mn, mm);
    @(negedge clk);
    tag = t; instrWord = w; rnVal = rn; rmVal = rm; memNVal = mn; memMVal = mm;
    instrValid = 1'b1;
    @(negedge clk);
    instrValid = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    issue("R2", 16'h3A1D, 32'hFFFF_FFFD, 32'h0001_0007, 0, 0);
    issue("R2", 16'h312D, 32'h8000_0000, 32'h8000_0000, 0, 0);
    issue("R3", 16'h3005, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0);
    issue("R4", 16'h0567, 32'h1234_5678, 32'h9ABC_DEF1, 0, 0);
    issue("R5", 16'h2F0F, 32'hAAAA_FFFE, 32'h5555_0003, 0, 0);
    issue("R5", 16'h207E, 32'h0000_FFFE, 32'h1111_0003, 0, 0);
    issue("R6", 16'h0CDF, 32'h0000_1000, 32'h0000_2000, 32'hFFFF_FFF0, 32'h0000_0010);
    issue("R6", 16'h0FFF, 32'hFFFF_FFFE, 32'h0000_0004, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    issue("R7", 16'h4ABF, 32'h0000_0100, 32'h0000_0200, 32'h1234_8000, 32'h0000_7FFF);
    issue("R10", 16'hFFFF, 32'h1, 32'h2, 32'h3, 32'h4);
    issue("R10", 16'h3A1C, 32'h1, 32'h2, 32'h3, 32'h4);
    // R9: second request made while busy must vanish
    @(negedge clk);
    tag = "R9"; instrWord = 16'h3005; rnVal = 7; rmVal = 9; instrValid = 1'b1;
    @(negedge clk);
    instrWord = 16'h0FFF; memNVal = 32'h100; memMVal = 32'h100;
    repeat (LONG - 1) @(negedge clk);
    instrValid = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    // R1: random mix with varied register fields
    for (int i = 0; i < 200; i++) begin
      logic [15:0] base;
      case ($urandom_range(0, 7))
        0: base = 16'h300D; 1: base = 16'h3005; 2: base = 16'h0007;
        3: base = 16'h200F; 4: base = 16'h200E; 5: base = 16'h000F;
        6: base = 16'h400F; default: base = 16'h6007;
      endcase
      base[11:4] = 8'($urandom);
      issue("R1", base, $urandom, $urandom, $urandom, $urandom);
    end
    // R11: reset mid-flight clears everything
    @(negedge clk);
    tag = "R11"; instrWord = 16'h3005; rnVal = 5; rmVal = 5; instrValid = 1'b1;
    @(negedge clk);
    instrValid = 1'b0; rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule